// File: doc/BRIEF.md
# Bidirectional Interleaved Shift-Latch Driver

This block is the digital core of a wide serial-to-parallel display driver. It has four shift lanes, each 16 stages deep. All four lanes advance on every rising clock edge, so four serial bits enter per cycle and the 64-stage image fills in 16 cycles. The lanes are interleaved across the parallel outputs: lane k owns every fourth output, starting at output k. A direction select sets which end of each lane takes new data. It also sets which of the two 4-bit ports acts as the serial input and which acts as the cascade output, so several devices can be chained in either direction.

Behind the lanes sits a 64-bit hold bank. While load is high, the bank shows the current shift contents. While load is low, it keeps the image it last showed. A final gating stage then either forces every output to one level or passes the held image, straight or inverted. The level it forces, and the choice between straight and inverted, both depend on the polarity input. Shifting never depends on load, blank or polarity, so a new frame can be shifted in while the current one is displayed.

Top module: `ilsd_driver`

## Requirements
- R1: Driving `rst_n` low clears every shift stage and every hold bit at once. After reset, with `load_en`=1, `blank_n`=1 and `pol_pass`=1, `drv_out` is all zeros and both `a_out` and `b_out` are zero.
- R2: All four lanes advance together on every rising clock edge. Stage s of lane k (k=0..3, s=0..15) drives output bit 4*s+k, so stage 0 of lane 0 drives `drv_out[0]` and stage 15 of lane 3 drives `drv_out[63]`.
- R3: With `dir_fwd`=1, each stage s takes the value of stage s-1, and `a_in[k]` enters stage 0 of lane k. `b_in` has no effect.
- R4: With `dir_fwd`=0, each stage s takes the value of stage s+1, and `b_in[k]` enters stage 15 of lane k. `a_in` has no effect.
- R5: With `dir_fwd`=1, `b_out[k]` shows stage 15 of lane k (image bit 60+k) and `a_out` is zero. With `dir_fwd`=0, `a_out[k]` shows stage 0 of lane k (image bit k) and `b_out` is zero. Both ports follow the current state without waiting for a clock edge.
- R6: While `load_en`=1, the hold bank shows the current shift contents in the same cycle, and it captures them at the next clock edge. While `load_en`=0, the hold bank keeps its value.
- R7: With `blank_n`=0, every `drv_out` bit equals the inverse of `pol_pass`: all ones when `pol_pass`=0 and all zeros when `pol_pass`=1.
- R8: With `blank_n`=1, `drv_out` equals the held image when `pol_pass`=1 and the bitwise inverse of the held image when `pol_pass`=0.
- R9: The shift contents advance in the same way whatever the values of `load_en`, `blank_n` and `pol_pass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: data moves toward output 63, port A in and port B out; 0: data moves toward output 0, port B in and port A out |
| load_en | input | 1 | 1: hold bank is transparent; 0: hold bank keeps its value |
| blank_n | input | 1 | 0: force all outputs to the inverse of `pol_pass` |
| pol_pass | input | 1 | With `blank_n`=1: 1 passes the held image, 0 inverts it |
| a_in | input | 4 | Serial input per lane, used when `dir_fwd`=1 |
| a_out | output | 4 | Cascade output, lane stage 0, when `dir_fwd`=0; zero otherwise |
| b_in | input | 4 | Serial input per lane, used when `dir_fwd`=0 |
| b_out | output | 4 | Cascade output, lane stage 15, when `dir_fwd`=1; zero otherwise |
| drv_out | output | 64 | Gated parallel outputs |

## Verification
The assertions are checked on every cycle, and they cover the behaviour that is local to one or two cycles. They check that a forced blank gives the level set by polarity. They check that the idle cascade port stays at zero. They check that the held image stays steady while load is low. They check that a fresh serial nibble shows up at the entry end of the image one cycle after it is sampled, in either direction.

Some behaviour only the bench scenarios can show. This covers the full 16-cycle journey of data through the interleaved lanes and the bit order of the complete 64-bit image. It also covers the data arriving at the cascade port after a whole burst, the independence of shifting from the gating inputs, and a reset in the middle of a run. To see these, the bench compares every port against a bit-level reference model on every cycle.

// File: rtl/ilsd_pkg.sv
package ilsd_pkg;
  parameter int unsigned LANES_DEF = 4;
  parameter int unsigned DEPTH_DEF = 16;

  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } dir_e;
endpackage

// File: rtl/ilsd_lane.sv
module ilsd_lane #(
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwd,
  input  logic             head_in,
  input  logic             tail_in,
  output logic [DEPTH-1:0] stage_q
);
  logic [DEPTH-1:0] stage_d;

  // next state: move toward the tail when forward, toward the head otherwise
  always_comb begin
    if (ilsd_pkg::dir_e'(fwd) == ilsd_pkg::DIR_FWD) begin
      stage_d = {stage_q[DEPTH-2:0], head_in};
    end else begin
      stage_d = {tail_in, stage_q[DEPTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end
endmodule

// File: rtl/ilsd_hold.sv
module ilsd_hold #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] vis_out
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;

  // transparent behaviour built from a flop plus a bypass mux
  always_comb begin
    hold_d  = load_en ? par_in : hold_q;
    vis_out = load_en ? par_in : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/ilsd_gate.sv
module ilsd_gate #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             blank_n,
  input  logic             pol_pass,
  input  logic [WIDTH-1:0] vis_in,
  output logic [WIDTH-1:0] drv_out
);
  always_comb begin
    if (!blank_n) begin
      drv_out = {WIDTH{~pol_pass}};
    end else if (pol_pass) begin
      drv_out = vis_in;
    end else begin
      drv_out = ~vis_in;
    end
  end
endmodule

// File: rtl/ilsd_driver.sv
module ilsd_driver #(
  parameter int unsigned LANES = ilsd_pkg::LANES_DEF,
  parameter int unsigned DEPTH = ilsd_pkg::DEPTH_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dir_fwd,
  input  logic                   load_en,
  input  logic                   blank_n,
  input  logic                   pol_pass,
  input  logic [LANES-1:0]       a_in,
  output logic [LANES-1:0]       a_out,
  input  logic [LANES-1:0]       b_in,
  output logic [LANES-1:0]       b_out,
  output logic [LANES*DEPTH-1:0] drv_out
);
  localparam int unsigned WIDTH = LANES * DEPTH;

  logic [DEPTH-1:0] lane_st [LANES];
  logic [WIDTH-1:0] image;
  logic [WIDTH-1:0] vis;
  logic [LANES-1:0] head_bits;
  logic [LANES-1:0] tail_bits;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ilsd_lane #(.DEPTH(DEPTH)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .fwd     (dir_fwd),
      .head_in (a_in[k]),
      .tail_in (b_in[k]),
      .stage_q (lane_st[k])
    );
    assign head_bits[k] = lane_st[k][0];
    assign tail_bits[k] = lane_st[k][DEPTH-1];
    // interleave: stage s of lane k lands on bit s*LANES+k
    for (genvar s = 0; s < DEPTH; s++) begin : g_map
      assign image[s*LANES+k] = lane_st[k][s];
    end
  end

  // cascade ports: only the port facing downstream carries data
  always_comb begin
    if (ilsd_pkg::dir_e'(dir_fwd) == ilsd_pkg::DIR_FWD) begin
      a_out = '0;
      b_out = tail_bits;
    end else begin
      a_out = head_bits;
      b_out = '0;
    end
  end

  ilsd_hold #(.WIDTH(WIDTH)) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .par_in  (image),
    .vis_out (vis)
  );

  ilsd_gate #(.WIDTH(WIDTH)) gate_i (
    .blank_n  (blank_n),
    .pol_pass (pol_pass),
    .vis_in   (vis),
    .drv_out  (drv_out)
  );
endmodule

// File: rtl/ilsd_checker.sv
module ilsd_checker #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   dir_fwd,
  input logic                   load_en,
  input logic                   blank_n,
  input logic                   pol_pass,
  input logic [LANES-1:0]       a_in,
  input logic [LANES-1:0]       a_out,
  input logic [LANES-1:0]       b_in,
  input logic [LANES-1:0]       b_out,
  input logic [LANES*DEPTH-1:0] drv_out
);
  localparam int unsigned WIDTH = LANES * DEPTH;

  logic open_view;
  assign open_view = load_en && blank_n && pol_pass;

  assert_blank_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> drv_out == {WIDTH{~pol_pass}});

  assert_idle_port_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |-> a_out == '0);

  assert_idle_port_rev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |-> b_out == '0);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && blank_n && pol_pass) |=> ((!load_en && blank_n && pol_pass) -> $stable(drv_out)));

  assert_fwd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |=> (open_view -> drv_out[LANES-1:0] == $past(a_in)));

  assert_rev_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |=> (open_view -> drv_out[WIDTH-1 -: LANES] == $past(b_in)));
endmodule

bind ilsd_driver ilsd_checker #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/ilsd_driver_tb_top.sv
module ilsd_driver_tb_top;
  logic        clk;
  logic        rst_n;
  logic        dir_fwd;
  logic        load_en;
  logic        blank_n;
  logic        pol_pass;
  logic [3:0]  a_in;
  logic [3:0]  a_out;
  logic [3:0]  b_in;
  logic [3:0]  b_out;
  logic [63:0] drv_out;

  typedef struct {
    logic [63:0] out;
    logic [3:0]  a;
    logic [3:0]  b;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  event        ev_push;
  int          checks;
  int          errors;
  bit          done;
  logic [63:0] m_sr;
  logic [63:0] m_hold;

  ilsd_driver dut_i (
    .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .load_en(load_en),
    .blank_n(blank_n), .pol_pass(pol_pass), .a_in(a_in), .a_out(a_out),
    .b_in(b_in), .b_out(b_out), .drv_out(drv_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pop one expected item per driven cycle and compare
  initial begin
    forever begin
      @(ev_push);
      #1;
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (drv_out !== it.out) begin
          errors++;
          $display("FAIL %s drv_out actual %h expected %h", it.tag, drv_out, it.out);
        end
        checks++;
        if (a_out !== it.a) begin
          errors++;
          $display("FAIL %s a_out actual %h expected %h", it.tag, a_out, it.a);
        end
        checks++;
        if (b_out !== it.b) begin
          errors++;
          $display("FAIL %s b_out actual %h expected %h", it.tag, b_out, it.b);
        end
      end
    end
  end

  function automatic exp_t predict(logic dir, logic le, logic bl, logic pol, string tag);
    exp_t e;
    logic [63:0] vis;
    vis   = le ? m_sr : m_hold;
    e.out = bl ? (pol ? vis : ~vis) : {64{~pol}};
    e.a   = dir ? 4'h0 : m_sr[3:0];
    e.b   = dir ? m_sr[63:60] : 4'h0;
    e.tag = tag;
    return e;
  endfunction

  // driver: apply one cycle of inputs, push expectation, advance the model
  task automatic step(input logic dir, input logic [3:0] ai, input logic [3:0] bi,
                      input logic le, input logic bl, input logic pol, input string tag);
    @(negedge clk);
    dir_fwd = dir; a_in = ai; b_in = bi; load_en = le; blank_n = bl; pol_pass = pol;
    sb_q.push_back(predict(dir, le, bl, pol, tag));
    ->ev_push;
    if (le) m_hold = m_sr;
    m_sr = dir ? {m_sr[59:0], ai} : {bi, m_sr[63:4]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    load_en = 1'b1; blank_n = 1'b1; pol_pass = 1'b1;
    m_sr = '0; m_hold = '0;
    #0.5;
    sb_q.push_back(predict(dir_fwd, 1'b1, 1'b1, 1'b1, "R1"));
    ->ev_push;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; dir_fwd = 1'b1; load_en = 1'b0; blank_n = 1'b1; pol_pass = 1'b1;
    a_in = '0; b_in = '0;
    m_sr = '0; m_hold = '0;

    // R1: reset state
    do_reset();
    step(1'b1, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, "R1");

    // R3 R5: forward burst, hold closed (R6), b_in ignored
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 4'(i * 5 + 3), 4'($urandom), 1'b0, 1'b1, 1'b1, "R3");
    end
    // R2: open the hold bank and view the interleaved image
    step(1'b1, 4'hA, 4'h5, 1'b1, 1'b1, 1'b1, "R2");
    // R6: closed again, image must stay while shifting continues
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 4'($urandom), 4'($urandom), 1'b0, 1'b1, 1'b1, "R6");
    end
    // R8: inversion of held image
    step(1'b1, 4'h1, 4'h2, 1'b0, 1'b1, 1'b0, "R8");
    // R7: both forced levels
    step(1'b1, 4'h3, 4'h4, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 4'h5, 4'h6, 1'b1, 1'b0, 1'b1, "R7");

    // R4 R5: reverse burst, a_in ignored
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 4'($urandom), 4'(i * 7 + 1), 1'b0, 1'b1, 1'b1, "R4");
    end
    step(1'b0, 4'hF, 4'h9, 1'b1, 1'b1, 1'b1, "R4");
    step(1'b0, 4'h0, 4'h6, 1'b1, 1'b1, 1'b0, "R8");

    // R9: shifting with scrambled gating inputs, both directions
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R9");
    end
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R9");
    end
    step(1'b1, 4'h0, 4'h0, 1'b1, 1'b1, 1'b1, "R9");

    // R1: reset in the middle of a loaded run
    do_reset();
    step(1'b0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, "R1");

    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule